// File: doc/BRIEF.md
# Fault-Tolerant Reference Tick Selector

One node of a group of N mutually locked clocks uses this block to decide, once per sampling window, which peer tick serves as its phase reference. The choice is made so that up to m peers that misbehave in any way cannot split the group into separate clusters or pull its timing outside the span of the healthy clocks. The block receives one tick line from each of the N-1 peers plus the node's own tick. All lines must already be synchronous to the local sampling clock.

A window counter stamps the first rising edge on every line. A line that stays silent for the whole window gets the last window slot as its stamp. When the window closes, the stamps are frozen. The block then ranks the N entries and works out where the node's own tick falls in that order. From that position it picks a reference rank k. The reference is the k-th peer in arrival order: k = 2m while the own tick is among the first N-m entries, and k = m+1 once it falls later. This rank always lies between m+1 and N-m-1, so a faulty reference sits between healthy ticks. The result is a registered one-cycle pulse carrying the reference stamp, the index of the chosen peer and the signed phase error. The loop filter that consumes the error is outside this block.

Top module: `tick_ref_select`

## Requirements
- R1: Each line is stamped with the window counter value (0 to WIN_LEN-1) in the first cycle in which it is sampled high after being sampled low within the window; later rising edges on that line in the same window change nothing.
- R2: A line with no rising edge in a window is stamped WIN_LEN-1.
- R3: The own position p equals 1 plus the number of peers whose stamp is strictly smaller than the own stamp, so the own tick ranks ahead of peers with the same stamp; when p > N-m the reference rank is m+1.
- R4: Peers are ordered by stamp, ties going to the lower peer index; the own tick is not counted; when p <= N-m the reference is the peer at rank 2m, and ref_sel gives its peer index (peer_tick bit number).
- R5: ref_ts equals the frozen stamp of the chosen peer.
- R6: phase_err equals own stamp minus reference stamp as a signed two's-complement value of TS_W+1 bits.
- R7: ready is a one-cycle pulse, exactly one per completed window, high in the cycle in which the window counter holds 1, that is two clock edges after the last slot of the window was sampled.
- R8: The configuration must satisfy N_CLK >= 3*M_FAULT+1 with M_FAULT >= 1, or elaboration fails; the rank of the chosen peer among the peers always lies between M_FAULT+1 and N_CLK-M_FAULT-1.
- R9: Synchronous active-high reset clears all stamps, restarts the window at slot 0 and drives ready, ref_ts, ref_sel and phase_err to zero; edges seen before reset have no effect on later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| own_tick | input | 1 | The node's own clock tick |
| peer_tick | input | N_CLK-1 | Ticks from the peers, one bit per peer |
| ready | output | 1 | One-cycle result pulse per window |
| ref_ts | output | TS_W | Stamp of the chosen reference peer |
| ref_sel | output | SEL_W | Index of the chosen reference peer |
| phase_err | output | TS_W+1 | Own stamp minus reference stamp, signed |

## Verification
The hardest situation to reach is the switch of reference rank, which only happens when the own tick lands among the last m entries of the order while ties, silent peers and repeated edges also bend that order. The stimulus therefore sweeps the own stamp across every slot against a fixed spread of peers, then drives windows where all stamps collide, where several peers or the node itself stay silent, and where a second edge would reorder the entries if it were taken. Pseudo-random windows drawn from narrow stamp ranges add dense ties around the own tick, and a reset in the middle of a window shows that half-captured stamps are dropped.

// File: rtl/tick_ref_pkg.sv
package tick_ref_pkg;

  // Reference rank among the peers for a given own position.
  function automatic int unsigned ref_rank(input int unsigned pos,
                                           input int unsigned n_clk,
                                           input int unsigned m_fault);
    return (pos <= n_clk - m_fault) ? 2 * m_fault : m_fault + 1;
  endfunction

endpackage

// File: rtl/tick_capture.sv
module tick_capture #(
  parameter int TS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_in,
  input  logic            win_close,
  input  logic [TS_W-1:0] now,
  input  logic [TS_W-1:0] fill_val,
  output logic [TS_W-1:0] snap_ts
);

  logic            tick_d;
  logic            got;
  logic [TS_W-1:0] ts;
  logic            rise;

  assign rise = tick_in & ~tick_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_d  <= 1'b0;
      got     <= 1'b0;
      ts      <= '0;
      snap_ts <= '0;
    end else begin
      tick_d <= tick_in;
      if (win_close) begin
        got <= 1'b0;
        if (got)       snap_ts <= ts;
        else if (rise) snap_ts <= now;
        else           snap_ts <= fill_val;
      end else if (rise && !got) begin
        got <= 1'b1;
        ts  <= now;
      end
    end
  end

  // Once a line has been stamped, later edges in the window leave it alone.
  p_first_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (got && !win_close) |=> (got && $stable(ts)));

endmodule

// File: rtl/order_rank.sv
module order_rank #(
  parameter int N_PEER = 6,
  parameter int TS_W   = 4,
  parameter int POS_W  = 3
) (
  input  logic [TS_W-1:0]               own_ts,
  input  logic [N_PEER-1:0][TS_W-1:0]   peer_ts,
  output logic [POS_W-1:0]              own_pos,
  output logic [N_PEER-1:0][POS_W-1:0]  peer_rank
);

  // Own tick wins ties against peers: only strictly earlier peers count.
  always_comb begin
    own_pos = POS_W'(1);
    for (int i = 0; i < N_PEER; i++) begin
      if (peer_ts[i] < own_ts) own_pos = own_pos + POS_W'(1);
    end
  end

  // Rank of every peer among the peers, lower index first on equal stamps.
  always_comb begin
    for (int i = 0; i < N_PEER; i++) begin
      peer_rank[i] = POS_W'(1);
      for (int j = 0; j < N_PEER; j++) begin
        if (j != i) begin
          if ((peer_ts[j] < peer_ts[i]) ||
              ((peer_ts[j] == peer_ts[i]) && (j < i)))
            peer_rank[i] = peer_rank[i] + POS_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/ref_picker.sv
module ref_picker
  import tick_ref_pkg::*;
#(
  parameter int N_PEER  = 6,
  parameter int M_FAULT = 2,
  parameter int TS_W    = 4,
  parameter int POS_W   = 3,
  parameter int SEL_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          valid,
  input  logic [POS_W-1:0]              own_pos,
  input  logic [N_PEER-1:0][POS_W-1:0]  peer_rank,
  input  logic [N_PEER-1:0][TS_W-1:0]   peer_ts,
  output logic [SEL_W-1:0]              sel_idx,
  output logic [TS_W-1:0]               sel_ts
);

  localparam int N_CLK = N_PEER + 1;

  logic [POS_W-1:0]  k;
  logic [N_PEER-1:0] sel;

  always_comb begin
    k       = POS_W'(ref_rank(int'(own_pos), N_CLK, M_FAULT));
    sel_idx = '0;
    sel_ts  = '0;
    for (int i = 0; i < N_PEER; i++) begin
      sel[i] = (peer_rank[i] == k);
      if (sel[i]) begin
        sel_idx = sel_idx | SEL_W'(i);
        sel_ts  = sel_ts | peer_ts[i];
      end
    end
  end

  // Reference rank stays inside the bracketed band.
  p_rank_band_r8: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((int'(k) >= M_FAULT + 1) && (int'(k) <= N_PEER - M_FAULT)));

  // Exactly one peer carries the wanted rank.
  p_single_ref_r4: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($countones(sel) == 1));

endmodule

// File: rtl/tick_ref_select.sv
module tick_ref_select #(
  parameter int N_CLK   = 7,
  parameter int M_FAULT = 2,
  parameter int WIN_LEN = 16,
  localparam int TS_W   = $clog2(WIN_LEN),
  localparam int SEL_W  = $clog2(N_CLK - 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    own_tick,
  input  logic [N_CLK-2:0]        peer_tick,
  output logic                    ready,
  output logic [TS_W-1:0]         ref_ts,
  output logic [SEL_W-1:0]        ref_sel,
  output logic signed [TS_W:0]    phase_err
);

  localparam int N_PEER = N_CLK - 1;
  localparam int POS_W  = $clog2(N_CLK + 1);
  localparam logic [TS_W-1:0] LAST_SLOT = TS_W'(WIN_LEN - 1);

  if ((M_FAULT < 1) || (N_CLK < 3 * M_FAULT + 1) || (WIN_LEN < 3)) begin : g_bad_cfg
    $error("tick_ref_select: need M_FAULT>=1, N_CLK>=3*M_FAULT+1, WIN_LEN>=3");
  end

  logic [TS_W-1:0]              cnt;
  logic                         win_close;
  logic                         snap_vld;
  logic [TS_W-1:0]              own_snap;
  logic [N_PEER-1:0][TS_W-1:0]  peer_snap;
  logic [POS_W-1:0]             own_pos;
  logic [N_PEER-1:0][POS_W-1:0] peer_rank;
  logic [SEL_W-1:0]             sel_idx;
  logic [TS_W-1:0]              sel_ts;

  assign win_close = (cnt == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      snap_vld <= 1'b0;
    end else begin
      cnt      <= win_close ? '0 : cnt + TS_W'(1);
      snap_vld <= win_close;
    end
  end

  tick_capture #(.TS_W(TS_W)) u_own_cap (
    .clk(clk), .rst(rst), .tick_in(own_tick), .win_close(win_close),
    .now(cnt), .fill_val(LAST_SLOT), .snap_ts(own_snap)
  );

  for (genvar g = 0; g < N_PEER; g++) begin : g_peer_cap
    tick_capture #(.TS_W(TS_W)) u_cap (
      .clk(clk), .rst(rst), .tick_in(peer_tick[g]), .win_close(win_close),
      .now(cnt), .fill_val(LAST_SLOT), .snap_ts(peer_snap[g])
    );
  end

  order_rank #(.N_PEER(N_PEER), .TS_W(TS_W), .POS_W(POS_W)) u_rank (
    .own_ts(own_snap), .peer_ts(peer_snap),
    .own_pos(own_pos), .peer_rank(peer_rank)
  );

  ref_picker #(.N_PEER(N_PEER), .M_FAULT(M_FAULT), .TS_W(TS_W),
               .POS_W(POS_W), .SEL_W(SEL_W)) u_pick (
    .clk(clk), .rst(rst), .valid(snap_vld),
    .own_pos(own_pos), .peer_rank(peer_rank), .peer_ts(peer_snap),
    .sel_idx(sel_idx), .sel_ts(sel_ts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b0;
      ref_ts    <= '0;
      ref_sel   <= '0;
      phase_err <= '0;
    end else begin
      ready <= snap_vld;
      if (snap_vld) begin
        ref_ts    <= sel_ts;
        ref_sel   <= sel_idx;
        phase_err <= $signed({1'b0, own_snap}) - $signed({1'b0, sel_ts});
      end
    end
  end

  // Result pulse lasts a single cycle.
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // Result appears in window slot 1.
  p_ready_slot_r7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cnt == TS_W'(1)));

  // Chosen peer index is in range.
  p_sel_range_r4: assert property (@(posedge clk) disable iff (rst)
    ready |-> (int'(ref_sel) < N_PEER));

endmodule

// File: tb/tick_ref_select_tb.sv
module tick_ref_select_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_CLK   = 7;
  localparam int M_FAULT = 2;
  localparam int WIN_LEN = 16;
  localparam int TS_W    = $clog2(WIN_LEN);
  localparam int SEL_W   = $clog2(N_CLK - 1);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 own_tick = 1'b0;
  logic [N_CLK-2:0]     peer_tick = '0;
  logic                 ready;
  logic [TS_W-1:0]      ref_ts;
  logic [SEL_W-1:0]     ref_sel;
  logic signed [TS_W:0] phase_err;

  tick_ref_select #(.N_CLK(N_CLK), .M_FAULT(M_FAULT), .WIN_LEN(WIN_LEN)) u_dut (
    .clk(clk), .rst(rst), .own_tick(own_tick), .peer_tick(peer_tick),
    .ready(ready), .ref_ts(ref_ts), .ref_sel(ref_sel), .phase_err(phase_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  // index 0 = own tick, 1..N_CLK-1 = peer_tick[i-1]; value WIN_LEN = silent
  int tsv [N_CLK];
  int exv [N_CLK];

  bit    pend_valid = 0;
  int    exp_ts, exp_sel, exp_err, exp_pos;
  int    peer_ord [N_CLK];
  string tag_ts, tag_sel;

  logic [31:0] rng = 32'h1234_abcd;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return int'(rng[30:0]);
  endfunction

  // Expected result of the window just driven, from the requirements.
  task automatic compute_expected(input string override);
    int  e [N_CLK];
    bit  taken [N_CLK];
    bit  missing, extra;
    int  p, k, best;
    missing = 0;
    extra   = 0;
    for (int i = 0; i < N_CLK; i++) begin
      e[i]     = (tsv[i] >= WIN_LEN) ? WIN_LEN - 1 : tsv[i];   // R2
      taken[i] = 0;
      if (tsv[i] >= WIN_LEN) missing = 1;
      if (exv[i] >= 0) extra = 1;
    end
    p = 1;
    for (int i = 1; i < N_CLK; i++) if (e[i] < e[0]) p++;
    k = (p <= N_CLK - M_FAULT) ? 2 * M_FAULT : M_FAULT + 1;
    exp_sel = 0;
    for (int r = 1; r < N_CLK; r++) begin
      best = -1;
      for (int i = 1; i < N_CLK; i++)
        if (!taken[i] && (best < 0 || e[i] < e[best])) best = i;
      taken[best] = 1;
      peer_ord[best - 1] = r;
      if (r == k) exp_sel = best - 1;
    end
    exp_ts  = e[exp_sel + 1];
    exp_err = e[0] - exp_ts;
    exp_pos = p;
    if (override != "") begin
      tag_ts  = override;
      tag_sel = override;
    end else begin
      tag_ts  = missing ? "R2" : (extra ? "R1" : "R5");
      tag_sel = (p > N_CLK - M_FAULT) ? "R3" : "R4";
    end
    pend_valid = 1;
  endtask

  // Drives ncyc slots starting at the current negedge; checks the previous
  // window's result in slot 1.
  task automatic drive_slots(input int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      if (c == 1 && pend_valid) begin
        chk(ready === 1'b1, "R7", "ready in slot 1", int'(ready), 1);
        chk(int'(ref_ts) == exp_ts, tag_ts, "ref_ts", int'(ref_ts), exp_ts);
        chk(int'(ref_sel) == exp_sel, tag_sel, "ref_sel", int'(ref_sel), exp_sel);
        chk(int'(phase_err) == exp_err, "R6", "phase_err", int'(phase_err), exp_err);
        chk(peer_ord[ref_sel] >= M_FAULT + 1 && peer_ord[ref_sel] <= N_CLK - M_FAULT - 1,
            "R8", "rank of chosen peer", peer_ord[ref_sel], exp_pos);
        pend_valid = 0;
      end else if (ready !== 1'b0) begin
        chk(0, "R7", "ready outside slot 1", int'(ready), 0);
      end
      own_tick = (c == tsv[0]) || (c == exv[0]);
      for (int i = 1; i < N_CLK; i++)
        peer_tick[i - 1] = (c == tsv[i]) || (c == exv[i]);
      @(negedge clk);
    end
    own_tick  = 1'b0;
    peer_tick = '0;
  endtask

  task automatic run_window(input string override);
    drive_slots(WIN_LEN);
    compute_expected(override);
  endtask

  task automatic clear_extras();
    for (int i = 0; i < N_CLK; i++) exv[i] = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    clear_extras();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(ready === 1'b0, "R9", "ready in reset", int'(ready), 0);
    chk(ref_ts === '0, "R9", "ref_ts in reset", int'(ref_ts), 0);
    chk(ref_sel === '0, "R9", "ref_sel in reset", int'(ref_sel), 0);
    chk(phase_err === '0, "R9", "phase_err in reset", int'(phase_err), 0);
    rst = 1'b0;

    // Own stamp swept over every slot against spread peers (R3, R4).
    for (int o = 1; o <= WIN_LEN; o++) begin
      tsv[0] = o;
      for (int i = 1; i < N_CLK; i++) tsv[i] = 2 * i;
      run_window("");
    end

    // All stamps equal: own first, peer rank 4 is peer index 3.
    for (int i = 0; i < N_CLK; i++) tsv[i] = 5;
    run_window("");

    // Reversed peer order with ties to the own tick.
    for (int i = 1; i < N_CLK; i++) tsv[i] = 14 - 2 * i;
    tsv[0] = 6;
    run_window("");

    // Silent peers and a silent own tick (R2).
    tsv[0] = 4; tsv[1] = WIN_LEN; tsv[2] = WIN_LEN; tsv[3] = 3;
    tsv[4] = 7; tsv[5] = 9; tsv[6] = 2;
    run_window("");
    tsv[0] = WIN_LEN; tsv[1] = 1; tsv[2] = 3; tsv[3] = 5;
    tsv[4] = 7; tsv[5] = 9; tsv[6] = 11;
    run_window("");
    tsv[0] = 15; tsv[1] = WIN_LEN; tsv[2] = 15; tsv[3] = 2;
    tsv[4] = WIN_LEN; tsv[5] = 15; tsv[6] = 8;
    run_window("");

    // Later edges that would reorder the entries if taken (R1).
    tsv[0] = 12; tsv[1] = 2; tsv[2] = 10; tsv[3] = 11;
    tsv[4] = 13; tsv[5] = 14; tsv[6] = 3;
    exv[0] = 14; exv[3] = 13; exv[4] = 15;
    run_window("");
    tsv[0] = 1; tsv[1] = 6; tsv[2] = 2; tsv[3] = 8;
    tsv[4] = 3; tsv[5] = 12; tsv[6] = 4;
    exv[0] = 9; exv[2] = 11; exv[6] = 13; exv[3] = -1; exv[4] = -1;
    run_window("");
    clear_extras();

    // Pseudo-random windows with ties, silence and repeated edges.
    for (int w = 0; w < 400; w++) begin
      int mode;
      mode = nxt_rand() % 3;
      for (int i = 0; i < N_CLK; i++) begin
        case (mode)
          0:       tsv[i] = 1 + nxt_rand() % WIN_LEN;
          1:       tsv[i] = 1 + nxt_rand() % 4;
          default: tsv[i] = 6 + nxt_rand() % 5;
        endcase
        exv[i] = -1;
        if (tsv[i] + 2 <= WIN_LEN - 1 && (nxt_rand() % 4) == 0)
          exv[i] = tsv[i] + 2 + nxt_rand() % (WIN_LEN - 2 - tsv[i]);
      end
      run_window("");
    end
    clear_extras();

    // Reset in the middle of a window: early edges must leave no trace (R9).
    for (int i = 0; i < N_CLK; i++) tsv[i] = 1 + i;
    drive_slots(8);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready === 1'b0, "R9", "ready after mid-window reset", int'(ready), 0);
    rst = 1'b0;
    tsv[0] = 11; tsv[1] = 13; tsv[2] = 10; tsv[3] = 12;
    tsv[4] = 14; tsv[5] = 9;  tsv[6] = WIN_LEN;
    run_window("R9");

    // Flush the last result with an all-silent window.
    for (int i = 0; i < N_CLK; i++) tsv[i] = WIN_LEN;
    run_window("");
    drive_slots(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule